// File: doc/BRIEF.md
# Split-Request Rejoin Pipeline

This block takes a stream of input words, each holding a kept field in its upper bits and a lookup address in its lower bits. When a word is accepted, the kept field is parked in a side FIFO. In the same cycle the address goes out on a request channel to an external responder. The responder answers every address with a burst of `BEATS` words, one per cycle, after some delay. Answers come back in the order the requests were made.

The returned burst is gathered into one wide word. That wide word is paired with the oldest parked field and the pair is offered to a downstream sink. All four data interfaces use valid/ready handshakes:

- A transfer happens on a clock edge where both valid and ready are high.
- The output holds its valid and data steady until the sink takes it.
- While a completed wide word waits for the sink, the response channel is back-pressured.
- When the side FIFO is full, or the request channel is not ready, the input is stalled.

The FIFO depth limits how many requests can be outstanding. A depth of at least ceil((d+BEATS)/BEATS) is needed to keep one output every `BEATS` cycles when the responder delay is d.

Top module: `rejoin_pipe`

## Requirements
- R1: After reset, `out_valid` is 0 and `rsp_ready` is 1. With `in_valid` low, `req_valid` is 0. With the FIFO empty and `req_ready` high, `in_ready` is 1.
- R2: An input handshake happens on exactly the same edges as a request handshake. `req_addr` equals `in_data[ADDR_W-1:0]`. While `req_ready` is 0, no input is accepted.
- R3: Once `DEPTH` kept fields are parked and none has left, `in_ready` is 0 and no further input is accepted.
- R4: Response beat k of a burst (k = 0 first) lands in bits `[k*BEAT_W +: BEAT_W]` of the wide word.
- R5: `out_data` is `{kept_field, wide_word}`, with the kept field in the top `KEEP_W` bits. Outputs appear in input order. `out_valid` is high only when both a parked field and a complete wide word exist.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged on the next cycle.
- R7: While a completed wide word is not being taken, `rsp_ready` is 0. In a cycle where the output is taken, `rsp_ready` is 1.
- R8: An output can be taken in the same cycle as the first beat of the next burst is accepted. An input push and an output pop can also happen in the same cycle.
- R9: With the responder, request channel and sink all at full rate and `DEPTH` at least the bound above, consecutive outputs are exactly `BEATS` cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word can be accepted |
| in_data | input | KEEP_W+ADDR_W | Kept field in the upper bits, address in the lower bits |
| req_valid | output | 1 | Address request offered |
| req_ready | input | 1 | Responder accepts a request |
| req_addr | output | ADDR_W | Lookup address |
| rsp_valid | input | 1 | Response beat offered |
| rsp_ready | output | 1 | Response beat can be accepted |
| rsp_data | input | BEAT_W | Response beat |
| out_valid | output | 1 | Paired word offered |
| out_ready | input | 1 | Sink accepts the paired word |
| out_data | output | KEEP_W+BEAT_W*BEATS | Kept field concatenated with the wide word |

## Verification
The functions that can coincide are these two pairs:

- taking a finished pair while the first beat of the next burst is written into the gather register;
- pushing a new kept field while the FIFO head leaves.

A full-rate stream provokes the first pair. Randomly throttled handshakes on all four channels provoke the second. The bench counts the edges where each pair falls together and requires both counts to be non-zero. Every output is compared against a model that builds its expected words from the addresses the bench's responder saw, so a clobbered beat or a skipped FIFO entry shows up as a data mismatch.

// File: rtl/rejoin_pkg.sv
package rejoin_pkg;

  // Gather register state: filling with beats, or holding a finished wide word.
  typedef enum logic {
    GATHER_FILL = 1'b0,
    GATHER_HELD = 1'b1
  } gather_st_e;

  // Index width for a count that runs 0..n-1, never less than one bit.
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rejoin_fifo.sv
module rejoin_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  import rejoin_pkg::*;

  localparam int unsigned PW = idx_width(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill;

  assign full  = (fill == CW'(DEPTH));
  assign empty = (fill == '0);
  assign rdata = mem[rd_ptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  // R3: the parent must never push into a full store
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);

  // R5: a pair may only leave when a parked field exists
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  // R3: occupancy never exceeds the depth
  a_r3_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

endmodule

// File: rtl/rejoin_gather.sv
module rejoin_gather #(
  parameter int unsigned BW    = 8,
  parameter int unsigned BEATS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                beat_valid,
  output logic                beat_ready,
  input  logic [BW-1:0]       beat_data,
  output logic                word_valid,
  input  logic                word_take,
  output logic [BW*BEATS-1:0] word_data
);
  import rejoin_pkg::*;

  localparam int unsigned IW = idx_width(BEATS);

  gather_st_e                st_q;
  logic [IW-1:0]             idx_q;
  logic [BEATS-1:0][BW-1:0]  beat_q;
  logic                      beat_fire;
  logic                      last_beat;

  // A held word blocks new beats unless it leaves in this same cycle.
  assign beat_ready = (st_q == GATHER_FILL) || word_take;
  assign beat_fire  = beat_valid && beat_ready;
  assign last_beat  = (idx_q == IW'(BEATS - 1));
  assign word_valid = (st_q == GATHER_HELD);
  assign word_data  = beat_q;

  always_ff @(posedge clk) begin
    if (beat_fire) beat_q[idx_q] <= beat_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= GATHER_FILL;
      idx_q <= '0;
    end else begin
      if (word_take) st_q <= GATHER_FILL;
      if (beat_fire) begin
        if (last_beat) begin
          idx_q <= '0;
          st_q  <= GATHER_HELD;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  // R7: a held word that is not taken survives unchanged
  a_r7_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !word_take |=> word_valid && $stable(word_data));

  // R7: the parent only takes a word that is complete
  a_r7_take_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    word_take |-> word_valid);

  // R4: beat position never runs past the burst length
  a_r4_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IW'(BEATS - 1));

endmodule

// File: rtl/rejoin_pipe.sv
module rejoin_pipe #(
  parameter int unsigned KEEP_W = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BEAT_W = 8,
  parameter int unsigned BEATS  = 2,
  parameter int unsigned DEPTH  = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  output logic                             in_ready,
  input  logic [KEEP_W+ADDR_W-1:0]         in_data,
  output logic                             req_valid,
  input  logic                             req_ready,
  output logic [ADDR_W-1:0]                req_addr,
  input  logic                             rsp_valid,
  output logic                             rsp_ready,
  input  logic [BEAT_W-1:0]                rsp_data,
  output logic                             out_valid,
  input  logic                             out_ready,
  output logic [KEEP_W+BEAT_W*BEATS-1:0]   out_data
);

  localparam int unsigned IN_W   = KEEP_W + ADDR_W;
  localparam int unsigned WIDE_W = BEAT_W * BEATS;

  logic [KEEP_W-1:0] keep_field;
  logic [KEEP_W-1:0] fifo_head;
  logic              fifo_full, fifo_empty;
  logic              push, pop;
  logic              word_valid;
  logic [WIDE_W-1:0] word_data;

  assign keep_field = in_data[IN_W-1 -: KEEP_W];

  // Split: accept only when the side store has room and the request goes out now.
  assign in_ready  = req_ready && !fifo_full;
  assign req_valid = in_valid && !fifo_full;
  assign req_addr  = in_data[ADDR_W-1:0];
  assign push      = in_valid && in_ready;

  // Rejoin: pair the oldest parked field with the next finished wide word.
  assign out_valid = word_valid && !fifo_empty;
  assign out_data  = {fifo_head, word_data};
  assign pop       = out_valid && out_ready;

  rejoin_fifo #(
    .W     (KEEP_W),
    .DEPTH (DEPTH)
  ) u_park (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .wdata (keep_field),
    .pop   (pop),
    .rdata (fifo_head),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  rejoin_gather #(
    .BW    (BEAT_W),
    .BEATS (BEATS)
  ) u_gather (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_valid (rsp_valid),
    .beat_ready (rsp_ready),
    .beat_data  (rsp_data),
    .word_valid (word_valid),
    .word_take  (pop),
    .word_data  (word_data)
  );

  // R6: an offered pair is held steady until the sink takes it
  a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R5: every finished wide word has a parked field waiting for it
  a_r5_word_has_entry: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> !fifo_empty);

  // R2: a request leaves only together with an accepted input
  a_r2_req_with_input: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |-> in_valid && in_ready);

  // R7: a finished word that is not taken blocks the response channel
  a_r7_rsp_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !pop |-> !rsp_ready);

endmodule

// File: tb/rejoin_pipe_tb.sv
module rejoin_pipe_tb;
  localparam int KW = 8;
  localparam int AW = 8;
  localparam int BW = 8;
  localparam int NB = 2;
  localparam int DP = 6;
  localparam int DL = 5;
  localparam int IW = KW + AW;
  localparam int OW = KW + BW * NB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [IW-1:0] in_data = '0;
  logic req_valid, req_ready = 1'b1;
  logic [AW-1:0] req_addr;
  logic rsp_valid = 1'b0, rsp_ready;
  logic [BW-1:0] rsp_data = '0;
  logic out_valid, out_ready = 1'b1;
  logic [OW-1:0] out_data;

  always #10 clk = ~clk;

  rejoin_pipe #(.KEEP_W(KW), .ADDR_W(AW), .BEAT_W(BW), .BEATS(NB), .DEPTH(DP)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int total = 0, bad = 0;
  int cyc = 0, wd = 0;
  int in_n = 0, in_i = 0;
  int exp_w = 0, exp_r = 0;
  int pa_w = 0, pa_r = 0, bk = 0;
  int out_cnt = 0, co_pp = 0, co_pw = 0;
  int in_mode = 0, rq_mode = 0, rs_mode = 0, sk_mode = 0;
  bit in_en = 1'b0;
  logic [15:0] lf = 16'hACE1;
  logic [IW-1:0] stim [64];
  logic [OW-1:0] exp_q [64];
  logic [AW-1:0] pa_addr [64];
  int pa_t [64];
  int ot [64];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [BW-1:0] bt(input logic [AW-1:0] a, input int k);
    return BW'(a) ^ BW'(8'h35 + k * 8'h11);
  endfunction

  function automatic logic [OW-1:0] mk(input logic [IW-1:0] d);
    logic [BW*NB-1:0] w;
    for (int k = 0; k < NB; k++) w[k*BW +: BW] = bt(d[AW-1:0], k);
    return {d[IW-1 -: KW], w};
  endfunction

  function automatic logic pick(input int m, input logic b);
    return (m == 0) ? 1'b1 : (m == 1) ? 1'b0 : b;
  endfunction

  // Bench step: drive at the falling edge, then record what the next rising edge takes.
  always @(negedge clk) begin
    if (rst_n) begin
      bit pushf, reqf, rspf, popf;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      in_valid  = in_en && (in_i < in_n) && pick(in_mode == 0 ? 0 : 2, lf[0]);
      in_data   = stim[in_i % 64];
      req_ready = pick(rq_mode, lf[3]);
      if (pa_r != pa_w && cyc >= pa_t[pa_r % 64] && pick(rs_mode, lf[6])) begin
        rsp_valid = 1'b1;
        rsp_data  = bt(pa_addr[pa_r % 64], bk);
      end else begin
        rsp_valid = 1'b0;
        rsp_data  = '0;
      end
      out_ready = pick(sk_mode, lf[9]);
      #1;
      pushf = in_valid && in_ready;
      reqf  = req_valid && req_ready;
      rspf  = rsp_valid && rsp_ready;
      popf  = out_valid && out_ready;
      if (in_valid || req_valid) chk(pushf == reqf, "R2 handshake pairing", 64'(reqf), 64'(pushf));
      if (pushf) begin
        chk(req_addr == in_data[AW-1:0], "R2 address field", 64'(req_addr), 64'(in_data[AW-1:0]));
        exp_q[exp_w % 64] = mk(in_data);
        exp_w++;
        in_i++;
      end
      if (reqf) begin
        pa_addr[pa_w % 64] = req_addr;
        pa_t[pa_w % 64] = cyc + DL;
        pa_w++;
      end
      if (rspf) begin
        bk++;
        if (bk == NB) begin bk = 0; pa_r++; end
      end
      if (out_valid) chk(exp_r != exp_w, "R5 output without input", 64'(exp_r), 64'(exp_w));
      if (popf) begin
        chk(out_data == exp_q[exp_r % 64], "R4 R5 paired data", 64'(out_data), 64'(exp_q[exp_r % 64]));
        ot[out_cnt % 64] = cyc;
        out_cnt++;
        exp_r++;
      end
      if (popf && rspf) co_pp++;
      if (popf && pushf) co_pw++;
      cyc++;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp<=%0d", wd, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic load(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      stim[in_n % 64] = {KW'(seed * 7 + i * 13), AW'(i * 29 + seed)};
      in_n++;
    end
  endtask

  task automatic drain(input int limit);
    int t = 0;
    while (!(exp_r == exp_w && in_i == in_n && pa_r == pa_w) && t < limit) begin
      @(negedge clk);
      t++;
    end
    chk(t < limit, "drain", 64'(t), 64'(limit));
  endtask

  task automatic t_reset();
    #2;
    chk(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'(0));
    chk(req_valid == 1'b0, "R1 req_valid", 64'(req_valid), 64'(0));
    chk(rsp_ready == 1'b1, "R1 rsp_ready", 64'(rsp_ready), 64'(1));
    chk(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 64'(1));
  endtask

  task automatic t_stream();
    int s = out_cnt;
    in_mode = 0; rq_mode = 0; rs_mode = 0; sk_mode = 0;
    load(12, 3);
    in_en = 1'b1;
    drain(1000);
    for (int i = s + 1; i < s + 12; i++)
      chk(ot[i % 64] - ot[(i - 1) % 64] == NB, "R9 output spacing",
          64'(ot[i % 64] - ot[(i - 1) % 64]), 64'(NB));
  endtask

  task automatic t_reqstall();
    int w0 = exp_w;
    rq_mode = 1;
    load(4, 11);
    repeat (6) @(negedge clk);
    #2;
    chk(in_ready == 1'b0, "R2 stalled by request channel", 64'(in_ready), 64'(0));
    chk(req_valid == 1'b1, "R2 request offered", 64'(req_valid), 64'(1));
    chk(req_addr == stim[in_i % 64][AW-1:0], "R2 offered address", 64'(req_addr), 64'(stim[in_i % 64][AW-1:0]));
    chk(exp_w == w0, "R2 nothing accepted", 64'(exp_w), 64'(w0));
    rq_mode = 0;
    drain(1000);
  endtask

  task automatic t_fifo_full();
    int w0 = exp_w;
    logic [OW-1:0] d1;
    sk_mode = 1;
    load(DP + 2, 21);
    repeat (40) @(negedge clk);
    #2;
    chk(exp_w - w0 == DP, "R3 accepted count", 64'(exp_w - w0), 64'(DP));
    chk(in_valid && !in_ready, "R3 input stalled", 64'(in_ready), 64'(0));
    chk(out_valid == 1'b1, "R5 pair offered", 64'(out_valid), 64'(1));
    chk(out_data == exp_q[exp_r % 64], "R6 held pair", 64'(out_data), 64'(exp_q[exp_r % 64]));
    chk(rsp_ready == 1'b0, "R7 response blocked", 64'(rsp_ready), 64'(0));
    d1 = out_data;
    repeat (3) @(negedge clk);
    #2;
    chk(out_valid && out_data == d1, "R6 pair stable", 64'(out_data), 64'(d1));
    sk_mode = 0;
    @(negedge clk);
    #2;
    chk(rsp_ready == 1'b1, "R7 response open on take", 64'(rsp_ready), 64'(1));
    drain(1000);
  endtask

  task automatic t_throttle();
    in_mode = 1; rq_mode = 2; rs_mode = 2; sk_mode = 2;
    load(30, 37);
    drain(4000);
    in_mode = 0; rq_mode = 0; rs_mode = 0; sk_mode = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_stream();
    t_reqstall();
    t_fifo_full();
    t_throttle();
    chk(co_pp > 0, "R8 take with new beat", 64'(co_pp), 64'(1));
    chk(co_pw > 0, "R8 push with pop", 64'(co_pw), 64'(1));
    chk(out_cnt == exp_w, "R5 all outputs", 64'(out_cnt), 64'(exp_w));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule